// File: doc/BRIEF.md
# Critical Interrupt Entry Sequencer

This block performs the architectural state update for a critical-class interrupt, such as a watchdog timeout. It holds the machine state word, two critical save/restore registers and the watchdog status flag. A critical request, either an external line or the pending watchdog flag, is accepted only while the critical-enable bit of the machine state is set. On acceptance the block saves the next instruction address and the full machine state. It then clears every machine state bit except machine-check-enable, and one cycle later it pulses a fetch redirect to a fixed handler vector.

A return strobe reverses the entry. It copies the saved state back into the machine state register at the next edge and, in the same cycle as the strobe, redirects fetch to the saved address. The watchdog flag stays set until software writes a one to its position. If software re-enables critical interrupts before clearing the flag, the interrupt is taken again.

Top module: `crit_irq_seq`

## Requirements
- R1: After reset the machine state equals MSR_RST (zero by default), both save/restore registers are zero, the watchdog flag is 0 and redirect is low.
- R2: A request (crit_req high or watchdog flag set) is accepted only in a cycle where machine state bit CE_BIT (default 14) is 1 and rfci is low. Otherwise it changes no state and produces no redirect.
- R3: On acceptance csrr0 takes the value of next_ea at that edge.
- R4: On acceptance csrr1 takes the full machine state value held before the edge.
- R5: On acceptance the new machine state keeps only bit ME_BIT (default 12) of its old value, and all other bits become 0.
- R6: redirect is high for exactly one cycle, the cycle after acceptance, with redirect_addr equal to VECTOR.
- R7: The watchdog flag is set by wdog_event. It is cleared only by tsr_we with tsr_wdata bit WIS_BIT (default 30) equal to 1. A write with that bit 0 leaves it set.
- R8: When wdog_event and a clearing write occur in the same cycle, the flag ends set.
- R9: A watchdog flag still set when critical-enable is restored causes a new entry. Once cleared, restoring critical-enable causes none.
- R10: While rfci is high, redirect is high in that same cycle with redirect_addr equal to csrr0, and at the next edge the machine state takes csrr1. rfci takes precedence over acceptance and over msr_we.
- R11: msr_we loads msr_wdata into the machine state at the next edge only when neither rfci nor an acceptance occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msr_we | input | 1 | Software write of the machine state |
| msr_wdata | input | MW | Machine state write value |
| next_ea | input | AW | Address of the next instruction |
| crit_req | input | 1 | External critical interrupt request |
| wdog_event | input | 1 | Watchdog timeout event, sets the flag |
| tsr_we | input | 1 | Timer status write strobe |
| tsr_wdata | input | TW | Timer status write data, write-one-to-clear |
| rfci | input | 1 | Return from critical interrupt |
| msr | output | MW | Current machine state |
| csrr0 | output | AW | Saved return address |
| csrr1 | output | MW | Saved machine state |
| wis | output | 1 | Watchdog interrupt status flag |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_addr | output | AW | Fetch redirect target |

## Verification
The assertions take for granted that rfci is raised only while a handler is active. They also assume it is never high in the cycle right after an entry, because the two redirect sources would then compete for redirect_addr. The directed scenarios always let an entry settle for a cycle before returning. The random phase keeps rfci rare and masks it in any cycle that follows an expected entry. Every other input is left free, including collisions of msr_we, rfci and requests.

// File: rtl/crit_irq_seq.sv
module crit_irq_seq #(
  parameter int AW = 32,
  parameter int MW = 32,
  parameter int TW = 32,
  parameter int CE_BIT = 14,
  parameter int ME_BIT = 12,
  parameter int WIS_BIT = 30,
  parameter logic [AW-1:0] VECTOR = 'h100,
  parameter logic [MW-1:0] MSR_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msr_we,
  input  logic [MW-1:0] msr_wdata,
  input  logic [AW-1:0] next_ea,
  input  logic          crit_req,
  input  logic          wdog_event,
  input  logic          tsr_we,
  input  logic [TW-1:0] tsr_wdata,
  input  logic          rfci,
  output logic [MW-1:0] msr,
  output logic [AW-1:0] csrr0,
  output logic [MW-1:0] csrr1,
  output logic          wis,
  output logic          redirect,
  output logic [AW-1:0] redirect_addr
);
  localparam logic [MW-1:0] KEEP = {{(MW-1){1'b0}}, 1'b1} << ME_BIT;

  logic [MW-1:0] msr_q, csrr1_q;
  logic [AW-1:0] csrr0_q;
  logic          wis_q, redir_q, take, wis_clr;

  assign take    = (crit_req | wis_q) & msr_q[CE_BIT] & ~rfci;
  assign wis_clr = tsr_we & tsr_wdata[WIS_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msr_q   <= MSR_RST;
      csrr0_q <= '0;
      csrr1_q <= '0;
      wis_q   <= 1'b0;
      redir_q <= 1'b0;
    end else begin
      redir_q <= take;
      wis_q   <= wdog_event | (wis_q & ~wis_clr);
      if (rfci)
        msr_q <= csrr1_q;
      else if (take) begin
        msr_q   <= msr_q & KEEP;
        csrr0_q <= next_ea;
        csrr1_q <= msr_q;
      end else if (msr_we)
        msr_q <= msr_wdata;
    end
  end

  assign msr           = msr_q;
  assign csrr0         = csrr0_q;
  assign csrr1         = csrr1_q;
  assign wis           = wis_q;
  assign redirect      = redir_q | rfci;
  assign redirect_addr = rfci ? csrr0_q : VECTOR;

  a_r2_gated_by_ce: assert property (@(posedge clk) disable iff (!rst_n)
    redir_q |-> $past(msr_q[CE_BIT]) && !$past(rfci));
  a_r3_save_pc: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> csrr0_q == $past(next_ea));
  a_r4_save_msr: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> csrr1_q == $past(msr_q));
  a_r5_clear_msr: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> msr_q == ($past(msr_q) & KEEP));
  a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    redir_q |=> !redir_q);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wis_q && !(tsr_we && tsr_wdata[WIS_BIT])) |=> wis_q);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_event |=> wis_q);
  a_r10_restore: assert property (@(posedge clk) disable iff (!rst_n)
    rfci |=> msr_q == $past(csrr1_q));
endmodule

// File: tb/test_crit_irq_seq.sv
module test_crit_irq_seq;
  localparam int AW = 32, MW = 32, TW = 32;
  localparam int CE = 14, ME = 12, WB = 30;
  localparam logic [AW-1:0] VEC = 'h100;

  logic clk = 0, rst_n = 0;
  logic msr_we = 0, crit_req = 0, wdog_event = 0, tsr_we = 0, rfci = 0;
  logic [MW-1:0] msr_wdata = '0;
  logic [AW-1:0] next_ea = '0;
  logic [TW-1:0] tsr_wdata = '0;
  logic [MW-1:0] msr, csrr1;
  logic [AW-1:0] csrr0, redirect_addr;
  logic wis, redirect;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  crit_irq_seq i_crit_irq_seq (
    .clk(clk), .rst_n(rst_n), .msr_we(msr_we), .msr_wdata(msr_wdata),
    .next_ea(next_ea), .crit_req(crit_req), .wdog_event(wdog_event),
    .tsr_we(tsr_we), .tsr_wdata(tsr_wdata), .rfci(rfci), .msr(msr),
    .csrr0(csrr0), .csrr1(csrr1), .wis(wis), .redirect(redirect),
    .redirect_addr(redirect_addr));

  // behavioural reference
  logic [MW-1:0] m_msr, m_c1;
  logic [AW-1:0] m_c0;
  logic m_wis, m_redir;

  always @(posedge clk) begin
    logic t;
    if (!rst_n) begin
      m_msr = '0; m_c0 = '0; m_c1 = '0; m_wis = 0; m_redir = 0;
    end else begin
      t = (crit_req || m_wis) && m_msr[CE] && !rfci;
      m_redir = t;
      if (rfci) m_msr = m_c1;
      else if (t) begin
        m_c0 = next_ea; m_c1 = m_msr;
        m_msr = m_msr & (MW'(1) << ME);
      end else if (msr_we) m_msr = msr_wdata;
      m_wis = wdog_event || (m_wis && !(tsr_we && tsr_wdata[WB]));
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R5/R10/R11 msr", 64'(msr), 64'(m_msr));
    chk("R3 csrr0", 64'(csrr0), 64'(m_c0));
    chk("R4 csrr1", 64'(csrr1), 64'(m_c1));
    chk("R7 wis", 64'(wis), 64'(m_wis));
    chk("R6/R10 redirect", 64'(redirect), 64'(m_redir || rfci));
    if (m_redir || rfci)
      chk("R6/R10 target", 64'(redirect_addr), 64'(rfci ? m_c0 : VEC));
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R1 msr", 64'(msr), 0); chk("R1 csrr0", 64'(csrr0), 0);
    chk("R1 wis", 64'(wis), 0); chk("R1 redirect", 64'(redirect), 0);
    // R2: request with CE clear
    crit_req = 1; step(); step(); crit_req = 0;
    @(negedge clk);
    chk("R2 no entry", 64'(redirect), 0); chk("R2 msr", 64'(msr), 0);
    // entry
    msr_we = 1; msr_wdata = 32'hA5A5_5000; step(); msr_we = 0;
    crit_req = 1; next_ea = 32'h1234; step(); crit_req = 0;
    @(negedge clk);
    chk("R6 pulse", 64'(redirect), 1); chk("R6 vector", 64'(redirect_addr), 64'(VEC));
    chk("R3 pc", 64'(csrr0), 64'h1234); chk("R4 saved", 64'(csrr1), 64'hA5A5_5000);
    chk("R5 cleared", 64'(msr), 64'h1000);
    step(); @(negedge clk); chk("R6 single", 64'(redirect), 0);
    // R10 return
    rfci = 1; @(negedge clk);
    chk("R10 same-cycle redirect", 64'(redirect), 1);
    chk("R10 target", 64'(redirect_addr), 64'h1234);
    step(); rfci = 0; @(negedge clk);
    chk("R10 restored", 64'(msr), 64'hA5A5_5000);
    // R7/R9 watchdog
    wdog_event = 1; next_ea = 32'h2000; step(); wdog_event = 0;
    step(); @(negedge clk);
    chk("R7 set", 64'(wis), 1); chk("R9 first entry", 64'(redirect), 1);
    tsr_we = 1; tsr_wdata = '0; step(); tsr_we = 0;
    @(negedge clk); chk("R7 zero write", 64'(wis), 1);
    rfci = 1; step(); rfci = 0; step(); @(negedge clk);
    chk("R9 retrigger", 64'(redirect), 1);
    tsr_we = 1; tsr_wdata = 32'(1) << WB; step(); tsr_we = 0;
    @(negedge clk); chk("R7 cleared", 64'(wis), 0);
    rfci = 1; step(); rfci = 0; step(); @(negedge clk);
    chk("R9 no retrigger", 64'(redirect), 0);
    // R8
    msr_we = 1; msr_wdata = '0; step(); msr_we = 0;
    wdog_event = 1; tsr_we = 1; tsr_wdata = 32'(1) << WB; step();
    wdog_event = 0; tsr_we = 0;
    @(negedge clk); chk("R8 set wins", 64'(wis), 1);
    // random
    for (int i = 0; i < 400; i++) begin
      logic exp_take;
      @(posedge clk); #2;
      exp_take = m_redir;
      msr_we     = ($urandom % 4) == 0;
      msr_wdata  = $urandom | (($urandom % 2) ? 32'h4000 : 0);
      next_ea    = $urandom;
      crit_req   = ($urandom % 5) == 0;
      wdog_event = ($urandom % 8) == 0;
      tsr_we     = ($urandom % 4) == 0;
      tsr_wdata  = $urandom;
      rfci       = !exp_take && (($urandom % 10) == 0);
    end
    step();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule